// File: doc/BRIEF.md
# Multichannel DAC Serial Command Front End

This block is the digital front end of a sixteen-channel digital-to-analog converter. A host talks to it as an SPI slave, sending 24-bit frames. Each frame holds a command byte and a 16-bit data word. The block decodes the command and updates its state. That state covers a double-buffered code per channel (an input register and a DAC register), a 3-bit output span, and four dither settings: power-down mask, source selection, scale, and invert mask. Everything the analog side needs leaves the block on parallel ports.

The serial lines are sampled with the system clock. A frame is acted on at the clock edge where chip select is seen to rise, and only if exactly 24 bits arrived. A readback command latches one channel's DAC code. The host receives that code on the serial output during the next frame, which is normally a no-operation frame. A parameter selects 16-bit or 12-bit resolution. At 12 bits the code is left-justified in the data word, and the four low bits are cleared.

Top module: `dac_cmd_frontend`

## Requirements
- R1: A frame is 24 bits sampled MSB first on rising serial-clock edges while chip select is low: command byte in bits 23..16, data word in bits 15..0. It is executed on the clock after chip select rises, and only when exactly 24 bits were received; shorter or longer frames change nothing.
- R2: Command 0x1n writes the data word to input register n without changing any DAC output; command 0x2n writes it to DAC register n only.
- R3: Command 0x30 copies all sixteen input registers into the DAC registers on the same clock.
- R4: Command 0x60 writes the data word into every DAC register.
- R5: Command 0x40 loads data bits 2..0 into the 3-bit span output; the other data bits are ignored.
- R6: Command 0x51 loads the 16-bit dither power-down mask, where bit k = 1 powers down channel k's dither; its reset value is all ones.
- R7: Commands 0x90 and 0xA0 load bits 15..0 and 31..16 of the 32-bit dither-source word, with channel k in bits 2k+1..2k, coded 01 for source N0 and 10 for source N1; after reset every channel holds 01.
- R8: Commands 0xC0 and 0xD0 load the low and high halves of the 32-bit dither-scale word, channel k in bits 2k+1..2k, coded 0 = 100 %, 1 = 75 %, 2 = 50 %, 3 = 25 %; reset value zero.
- R9: Command 0xB0 loads the 16-bit dither-invert mask, bit k for channel k; reset value zero.
- R10: Command 0x70 with data 0x1234 returns every register to its reset value; with any other data it changes nothing.
- R11: Command 0x8n latches DAC register n. During the next frame the serial output presents {8'h00, code} MSB first, each bit valid before the rising serial-clock edge that the host samples it on. Any frame that is not a readback leaves zeros for the following frame.
- R12: With RES = 12, bits 3..0 of every input and DAC register stay zero; the 12-bit code is taken from data bits 15..4.
- R13: Command bytes not listed above (for example 0x31, 0x41, 0x50, 0xE5) change no register.
- R14: While the synchronous active-high reset is high, all registers take their reset values (DAC and input codes zero, span zero). A frame that starts on the first clock after reset is released is executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial readback data to the host |
| dac_code | output | 256 | Sixteen 16-bit DAC codes, channel k in bits 16k+15..16k |
| span_code | output | 3 | Output range selection |
| dith_pd | output | 16 | Dither power-down mask, 1 = off |
| dith_src | output | 32 | Dither source, 2 one-hot bits per channel |
| dith_scl | output | 32 | Dither scale, 2 bits per channel |
| dith_inv | output | 16 | Dither invert mask |

## Verification
The bench goes after frame-length handling. A design that counted bits carelessly would act on a 20-bit or 25-bit frame and move the span. It also targets the reset key. A decoder that checked only the opcode would wipe the dither and DAC state on a wrong key such as 0x1235. Deferred readback is checked in both directions: a design that presented the code in the same frame, or failed to clear it afterwards, returns the wrong 24 bits. A 12-bit instance runs next to the 16-bit one, so a missing mask shows as nonzero low nibbles. Opcodes that differ from a valid one only in their low nibble (0x31, 0x41, 0x50) expose a decoder that compares only the high nibble.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

    localparam int N_CH    = 16;
    localparam int CH_W    = $clog2(N_CH);
    localparam int WORD_W  = 16;
    localparam int CMD_W   = 8;
    localparam int FRAME_W = CMD_W + WORD_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam int SPAN_W  = 3;
    localparam int DITH_W  = 2 * N_CH;

    localparam logic [WORD_W-1:0] RESET_KEY = 16'h1234;
    localparam logic [N_CH-1:0]   PD_INIT   = '1;
    localparam logic [DITH_W-1:0] SRC_INIT  = {N_CH{2'b01}};
    localparam logic [DITH_W-1:0] SCL_INIT  = '0;
    localparam logic [N_CH-1:0]   INV_INIT  = '0;

    typedef enum logic [3:0] {
        OP_NONE, OP_WR_IN, OP_WR_DAC, OP_LOAD_ALL, OP_SPAN, OP_PWR,
        OP_WR_ALL, OP_RESET, OP_READ, OP_SRC_LO, OP_SRC_HI, OP_INV,
        OP_SCL_LO, OP_SCL_HI
    } op_e;

    function automatic op_e decode_op(input logic [CMD_W-1:0] c,
                                      input logic [WORD_W-1:0] d);
        case (c[7:4])
            4'h1: return OP_WR_IN;
            4'h2: return OP_WR_DAC;
            4'h8: return OP_READ;
            default: begin
                case (c)
                    8'h30: return OP_LOAD_ALL;
                    8'h40: return OP_SPAN;
                    8'h51: return OP_PWR;
                    8'h60: return OP_WR_ALL;
                    8'h70: return (d == RESET_KEY) ? OP_RESET : OP_NONE;
                    8'h90: return OP_SRC_LO;
                    8'hA0: return OP_SRC_HI;
                    8'hB0: return OP_INV;
                    8'hC0: return OP_SCL_LO;
                    8'hD0: return OP_SCL_HI;
                    default: return OP_NONE;
                endcase
            end
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] code_mask(input int res);
        return {WORD_W{1'b1}} << (WORD_W - res);
    endfunction

endpackage

// File: rtl/dacfe_spi_rx.sv
module dacfe_spi_rx
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              rb_load,
    input  logic [WORD_W-1:0] rb_word,
    output logic              miso,
    output logic              frm_valid,
    output logic [CMD_W-1:0]  frm_cmd,
    output logic [WORD_W-1:0] frm_data
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    logic               sclk_q, cs_q;
    logic [FRAME_W-1:0] rx_sh, tx_sh;
    logic [CNT_W-1:0]   bit_cnt;
    logic               sclk_rise, cs_fall, cs_rise;

    assign sclk_rise = sclk & ~sclk_q & ~cs_n;
    assign cs_fall   = ~cs_n & cs_q;
    assign cs_rise   = cs_n & ~cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
        end else if (cs_fall) begin
            bit_cnt <= '0;
        end else if (sclk_rise) begin
            rx_sh <= {rx_sh[FRAME_W-2:0], mosi};
            if (bit_cnt != CNT_MAX)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            tx_sh <= '0;
        else if (rb_load)
            tx_sh <= {{CMD_W{1'b0}}, rb_word};
        else if (cs_rise)
            tx_sh <= '0;
        else if (sclk_rise)
            tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
    end

    assign miso      = tx_sh[FRAME_W-1];
    assign frm_valid = cs_rise && (bit_cnt == CNT_FULL);
    assign frm_cmd   = rx_sh[FRAME_W-1:WORD_W];
    assign frm_data  = rx_sh[WORD_W-1:0];
endmodule

// File: rtl/dacfe_chan_regs.sv
module dacfe_chan_regs
    import dacfe_pkg::*;
#(
    parameter int RES = 16
)(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   valid,
    input  op_e                    op,
    input  logic [CH_W-1:0]        ch,
    input  logic [WORD_W-1:0]      data,
    output logic [N_CH*WORD_W-1:0] in_flat,
    output logic [N_CH*WORD_W-1:0] dac_flat,
    output logic [WORD_W-1:0]      rb_word
);
    localparam logic [WORD_W-1:0] MASK = code_mask(RES);

    logic [WORD_W-1:0] wr_val;
    logic              clr;
    logic [WORD_W-1:0] dac_q [N_CH];

    assign wr_val = data & MASK;
    assign clr    = rst || (valid && op == OP_RESET);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        logic [WORD_W-1:0] in_q;
        logic              hit;
        assign hit = (ch == CH_W'(g));

        always_ff @(posedge clk) begin
            if (clr) begin
                in_q     <= '0;
                dac_q[g] <= '0;
            end else if (valid) begin
                case (op)
                    OP_WR_IN:    if (hit) in_q <= wr_val;
                    OP_WR_DAC:   if (hit) dac_q[g] <= wr_val;
                    OP_LOAD_ALL: dac_q[g] <= in_q;
                    OP_WR_ALL:   dac_q[g] <= wr_val;
                    default: ;
                endcase
            end
        end

        assign in_flat[g*WORD_W +: WORD_W]  = in_q;
        assign dac_flat[g*WORD_W +: WORD_W] = dac_q[g];
    end

    assign rb_word = dac_q[ch];
endmodule

// File: rtl/dacfe_cfg_regs.sv
module dacfe_cfg_regs
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  op_e               op,
    input  logic [WORD_W-1:0] data,
    output logic [SPAN_W-1:0] span,
    output logic [N_CH-1:0]   pwr,
    output logic [DITH_W-1:0] src,
    output logic [DITH_W-1:0] scl,
    output logic [N_CH-1:0]   inv
);
    always_ff @(posedge clk) begin
        if (rst || (valid && op == OP_RESET)) begin
            span <= '0;
            pwr  <= PD_INIT;
            src  <= SRC_INIT;
            scl  <= SCL_INIT;
            inv  <= INV_INIT;
        end else if (valid) begin
            case (op)
                OP_SPAN:   span <= data[SPAN_W-1:0];
                OP_PWR:    pwr  <= data;
                OP_SRC_LO: src[WORD_W-1:0]      <= data;
                OP_SRC_HI: src[DITH_W-1:WORD_W] <= data;
                OP_SCL_LO: scl[WORD_W-1:0]      <= data;
                OP_SCL_HI: scl[DITH_W-1:WORD_W] <= data;
                OP_INV:    inv  <= data;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dac_cmd_frontend.sv
module dac_cmd_frontend
    import dacfe_pkg::*;
#(
    parameter int RES = 16
)(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        spi_sclk,
    input  logic                        spi_cs_n,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic [N_CH*WORD_W-1:0]      dac_code,
    output logic [SPAN_W-1:0]           span_code,
    output logic [N_CH-1:0]             dith_pd,
    output logic [DITH_W-1:0]           dith_src,
    output logic [DITH_W-1:0]           dith_scl,
    output logic [N_CH-1:0]             dith_inv
);
    logic                   frm_valid;
    logic [CMD_W-1:0]       frm_cmd;
    logic [WORD_W-1:0]      frm_data;
    op_e                    frm_op;
    logic [WORD_W-1:0]      rb_word;
    logic                   rb_load;
    logic [N_CH*WORD_W-1:0] in_flat;

    assign frm_op  = decode_op(frm_cmd, frm_data);
    assign rb_load = frm_valid && (frm_op == OP_READ);

    dacfe_spi_rx u_rx (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .rb_load(rb_load), .rb_word(rb_word),
        .miso(spi_miso), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
        .frm_data(frm_data)
    );

    dacfe_chan_regs #(.RES(RES)) u_chan (
        .clk(clk), .rst(rst), .valid(frm_valid), .op(frm_op),
        .ch(frm_cmd[CH_W-1:0]), .data(frm_data), .in_flat(in_flat),
        .dac_flat(dac_code), .rb_word(rb_word)
    );

    dacfe_cfg_regs u_cfg (
        .clk(clk), .rst(rst), .valid(frm_valid), .op(frm_op),
        .data(frm_data), .span(span_code), .pwr(dith_pd),
        .src(dith_src), .scl(dith_scl), .inv(dith_inv)
    );
endmodule

// File: rtl/dac_cmd_frontend_chk.sv
module dac_cmd_frontend_chk
    import dacfe_pkg::*;
#(
    parameter int RES = 16
)(
    input logic                   clk,
    input logic                   rst,
    input logic                   frm_valid,
    input logic [CMD_W-1:0]       frm_cmd,
    input logic [WORD_W-1:0]      frm_data,
    input logic [N_CH*WORD_W-1:0] in_flat,
    input logic [N_CH*WORD_W-1:0] dac_code,
    input logic [SPAN_W-1:0]      span_code,
    input logic [N_CH-1:0]        dith_pd,
    input logic [DITH_W-1:0]      dith_src,
    input logic [DITH_W-1:0]      dith_scl,
    input logic [N_CH-1:0]        dith_inv
);
    localparam logic [N_CH*WORD_W-1:0] LOW_BITS = {N_CH{~code_mask(RES)}};

    logic [SPAN_W+2*N_CH+2*DITH_W-1:0] cfg_all;
    assign cfg_all = {span_code, dith_pd, dith_src, dith_scl, dith_inv};

    assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> $stable(cfg_all));

    assert_bad_key_R10: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_cmd == 8'h70 && frm_data != RESET_KEY)
        |=> ($stable(cfg_all) && $stable(dac_code)));

    assert_load_all_R3: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && frm_cmd == 8'h30) |=> (dac_code == $past(in_flat)));

    assert_low_bits_R12: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> ((dac_code & LOW_BITS) == '0 && (in_flat & LOW_BITS) == '0));

    assert_reset_vals_R14: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && span_code == '0 && dith_pd == PD_INIT &&
                 dith_src == SRC_INIT && dith_scl == SCL_INIT && dith_inv == INV_INIT));
endmodule

bind dac_cmd_frontend dac_cmd_frontend_chk #(.RES(RES)) u_chk (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_cmd(frm_cmd),
    .frm_data(frm_data), .in_flat(in_flat), .dac_code(dac_code),
    .span_code(span_code), .dith_pd(dith_pd), .dith_src(dith_src),
    .dith_scl(dith_scl), .dith_inv(dith_inv)
);

// File: tb/test_dac_cmd_frontend.sv
module test_dac_cmd_frontend;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1, sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso12;
    logic [255:0] dac, dac12;
    logic [2:0]   span, span12;
    logic [15:0]  pd, pd12, inv, inv12;
    logic [31:0]  src, src12, scl, scl12;

    dac_cmd_frontend i_dac_cmd_frontend (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso), .dac_code(dac), .span_code(span), .dith_pd(pd),
        .dith_src(src), .dith_scl(scl), .dith_inv(inv));

    dac_cmd_frontend #(.RES(12)) i_dac_cmd_frontend_12 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .spi_miso(miso12), .dac_code(dac12), .span_code(span12), .dith_pd(pd12),
        .dith_src(src12), .dith_scl(scl12), .dith_inv(inv12));

    int errors = 0, checks = 0;
    bit cmp_en = 0, done = 0;

    logic [15:0] m_in [16];
    logic [15:0] m_dac [16];
    logic [2:0]  m_span;
    logic [15:0] m_pd, m_inv;
    logic [31:0] m_src, m_scl;
    logic [23:0] exp_rx, exp_rx12;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 16; k++) begin m_in[k] = 0; m_dac[k] = 0; end
        m_span = 0; m_pd = 16'hFFFF; m_inv = 0; m_src = 32'h5555_5555; m_scl = 0;
    endtask

    task automatic model_apply(input logic [7:0] c, input logic [15:0] d);
        int n;
        n = c[3:0];
        exp_rx = 0; exp_rx12 = 0;
        case (c[7:4])
            4'h1: m_in[n] = d;
            4'h2: m_dac[n] = d;
            4'h8: begin exp_rx = {8'h00, m_dac[n]}; exp_rx12 = {8'h00, m_dac[n] & 16'hFFF0}; end
            default:
                case (c)
                    8'h30: for (int k = 0; k < 16; k++) m_dac[k] = m_in[k];
                    8'h40: m_span = d[2:0];
                    8'h51: m_pd = d;
                    8'h60: for (int k = 0; k < 16; k++) m_dac[k] = d;
                    8'h70: if (d == 16'h1234) model_reset();
                    8'h90: m_src[15:0] = d;
                    8'hA0: m_src[31:16] = d;
                    8'hB0: m_inv = d;
                    8'hC0: m_scl[15:0] = d;
                    8'hD0: m_scl[31:16] = d;
                    default: ;
                endcase
        endcase
    endtask

    // Per-clock comparison against the behavioural model (R2 R3 R4 R5 R6 R7 R8 R9 R12)
    always @(negedge clk) begin
        if (cmp_en) begin
            for (int k = 0; k < 16; k++) begin
                chk($sformatf("R2 model dac ch%0d", k), {16'h0, dac[16*k +: 16]}, {16'h0, m_dac[k]});
                chk($sformatf("R12 model dac12 ch%0d", k), {16'h0, dac12[16*k +: 16]},
                    {16'h0, m_dac[k] & 16'hFFF0});
            end
            chk("R5 model span", {29'h0, span}, {29'h0, m_span});
            chk("R6 model pd", {16'h0, pd}, {16'h0, m_pd});
            chk("R7 model src", src, m_src);
            chk("R8 model scl", scl, m_scl);
            chk("R9 model inv", {16'h0, inv}, {16'h0, m_inv});
        end
    end

    task automatic frame(input logic [7:0] c, input logic [15:0] d, input int nbits);
        logic [23:0] w, got, got12;
        w = {c, d}; got = 0; got12 = 0;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk);
            mosi = (i < 24) ? w[23-i] : 1'b0;
            if (i < 24) begin got[23-i] = miso; got12[23-i] = miso12; end
            @(negedge clk) sclk = 1'b1;
            @(negedge clk);
            @(negedge clk) sclk = 1'b0;
        end
        @(negedge clk) cs_n = 1'b1;
        if (nbits == 24) begin
            chk("R11 serial readback", {8'h0, got}, {8'h0, exp_rx});
            chk("R11 R12 serial readback 12-bit", {8'h0, got12}, {8'h0, exp_rx12});
        end
        @(posedge clk);
        #1;
        if (nbits == 24) model_apply(c, d);
        else begin exp_rx = 0; exp_rx12 = 0; end
        @(negedge clk);
    endtask

    function automatic logic [31:0] ch_of(input logic [255:0] v, input int k);
        return {16'h0, v[16*k +: 16]};
    endfunction

    initial begin
        model_reset();
        exp_rx = 0; exp_rx12 = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R14 reset dac ch0", ch_of(dac, 0), 0);
        chk("R6 reset pd all ones", {16'h0, pd}, 32'hFFFF);
        chk("R7 reset src all N0", src, 32'h5555_5555);
        cmp_en = 1;

        frame(8'h15, 16'h1111, 24);
        chk("R2 input write leaves dac5", ch_of(dac, 5), 0);
        frame(8'h23, 16'hBEEF, 24);
        chk("R2 dac write ch3", ch_of(dac, 3), 32'hBEEF);
        chk("R12 dac write ch3 12-bit", ch_of(dac12, 3), 32'hBEE0);
        frame(8'h30, 16'h0000, 24);
        chk("R3 load-all copies ch5", ch_of(dac, 5), 32'h1111);
        chk("R3 load-all copies ch3 zero", ch_of(dac, 3), 0);
        frame(8'h60, 16'h0F0F, 24);
        chk("R4 write-all ch0", ch_of(dac, 0), 32'h0F0F);
        chk("R4 write-all ch15", ch_of(dac, 15), 32'h0F0F);
        frame(8'h40, 16'h0006, 24);
        chk("R5 span 6", {29'h0, span}, 6);
        frame(8'h40, 16'hFFFD, 24);
        chk("R5 span upper bits ignored", {29'h0, span}, 5);
        frame(8'h51, 16'h00F0, 24);
        chk("R6 dither power mask", {16'h0, pd}, 32'h00F0);
        frame(8'h90, 16'h9999, 24);
        frame(8'hA0, 16'h6AA6, 24);
        chk("R7 dither source halves", src, 32'h6AA6_9999);
        frame(8'hC0, 16'h1B1B, 24);
        frame(8'hD0, 16'hE4E4, 24);
        chk("R8 dither scale halves", scl, 32'hE4E4_1B1B);
        frame(8'hB0, 16'hA005, 24);
        chk("R9 dither invert", {16'h0, inv}, 32'hA005);

        frame(8'h2A, 16'hC3A7, 24);
        frame(8'h8A, 16'h0000, 24);
        frame(8'h00, 16'h0000, 24);
        frame(8'h00, 16'h0000, 24);

        frame(8'h40, 16'h0001, 20);
        chk("R1 short frame discarded", {29'h0, span}, 5);
        frame(8'h40, 16'h0001, 25);
        chk("R1 long frame discarded", {29'h0, span}, 5);

        frame(8'h31, 16'h2222, 24);
        frame(8'h41, 16'h0002, 24);
        frame(8'h50, 16'h0000, 24);
        frame(8'hE5, 16'h7777, 24);
        chk("R13 unknown opcodes span", {29'h0, span}, 5);
        chk("R13 unknown opcodes dac ch10", ch_of(dac, 10), 32'hC3A7);

        frame(8'h70, 16'h1235, 24);
        chk("R10 wrong key keeps pd", {16'h0, pd}, 32'h00F0);
        frame(8'h70, 16'h1234, 24);
        chk("R10 key resets pd", {16'h0, pd}, 32'hFFFF);
        chk("R10 key resets dac ch10", ch_of(dac, 10), 0);

        frame(8'h40, 16'h0003, 24);
        cmp_en = 0;
        @(negedge clk) rst = 1'b1;
        repeat (12) @(negedge clk);
        rst = 1'b0;
        model_reset();
        exp_rx = 0; exp_rx12 = 0;
        cmp_en = 1;
        chk("R14 reset span", {29'h0, span}, 0);
        frame(8'h27, 16'h7777, 24);
        chk("R14 first frame after reset", ch_of(dac, 7), 32'h7777);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule